// File: doc/BRIEF.md
# Priority Interrupt Controller with Vector Acknowledge

This block gathers interrupt requests from a set of on-chip peripheral sources and presents one request line to the processor. Each source carries a programmable priority level and a recognition mode. An edge-mode source latches a pending flag on a rising input. A level-mode source follows its live input. A sequencer runs resolution passes of a fixed length. At the end of a pass it picks the best pending source whose level beats the current mask, captures its vector and raises the request.

Software reaches the block through a small register bus. Reading the vector register is the acknowledge. It returns the captured vector and loads the mask with the accepted level. It clears the accepted source if that source is edge-mode, drops the request and starts a new pass. Writing the mask register also drops the request and starts a new pass, even when the written value equals the old one. Stacking, processor status handling and the vector table memory itself lie outside the block.

Top module: `pic_top`

## Requirements
- R1: After reset the request output is low, the mask reads 7, the vector base reads 0, and every source configuration reads level 7 in edge mode.
- R2: A pending source can raise the request only if its level is numerically below the mask. Level 0 is the best priority and level 7 never requests.
- R3: Among eligible pending sources, the lowest level wins. A tie goes to the lowest source index.
- R4: The vector equals base + 4 × (winning source index), modulo 2^16. It is captured when the request is raised, and a later base write does not alter it.
- R5: A vector read while the request is high loads the mask with the accepted level, and the request is low in the following cycle.
- R6: An edge-mode source pends only on a 0→1 input change. Its pending flag is cleared by the acknowledge, so an input held high afterwards does not re-request.
- R7: A level-mode source is not cleared by the acknowledge. It requests again, with the same vector, once the mask is raised above its level while its input is still high. It stops requesting when its input falls.
- R8: Any mask write, including one that rewrites the current value, drops the request in the next cycle and starts a new pass.
- R9: A vector read while the request is low changes neither the mask nor any pending state. The mask changes only through a mask write or an acknowledge.
- R10: After a restart on a clock edge, the request stays low for RES_CYCLES cycles. If an eligible source is pending throughout, the request rises on the RES_CYCLES-th following edge.
- R11: Register map (word addresses, 16-bit data):
  - 0 is the vector register, read-only.
  - 1 is the mask register, bits 2:0.
  - 2 is the vector base.
  - 16+i configures source i, with bits 2:0 holding the level and bit 3 selecting the mode (1 = level mode).
  - Unmapped addresses read 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| irq_src | input | NSRC | Request inputs from peripherals, synchronous to clk |
| bus_rd | input | 1 | Read strobe, one cycle per access |
| bus_wr | input | 1 | Write strobe, one cycle per access |
| bus_addr | input | ADDR_W | Register word address |
| bus_wdata | input | VEC_W | Write data |
| bus_rdata | output | VEC_W | Read data, valid in the strobe cycle |
| irq_o | output | 1 | Interrupt request to the processor |

## Verification
The assertions assume that the source inputs are synchronous to the clock. They also assume that the bus never asserts read and write in the same cycle, so an acknowledge and a mask write never coincide. The stimulus drives all inputs on the falling edge and issues one single-cycle strobe at a time. In the random part, pulses are applied only after every earlier request has been drained. As a result, pending state changes only at points where the bench model can follow it.

// File: rtl/pic_pkg.sv
// Shared types and register map for the priority interrupt controller.
// Assumes 3-bit priority levels, where the all-ones level means disabled.
package pic_pkg;
    localparam int LVL_W = 3;
    typedef logic [LVL_W-1:0] lvl_t;
    localparam lvl_t LVL_OFF = '1;

    typedef enum logic {SEQ_PASS, SEQ_HOLD} seq_t;

    localparam int REG_VEC  = 0;
    localparam int REG_MASK = 1;
    localparam int REG_BASE = 2;
    localparam int REG_SRC0 = 16;
endpackage

// File: rtl/pic_pending.sv
// Pending latches. Edge-mode sources set a flag on a rising input and clear it
// on acknowledge. Level-mode sources pass the live input through.
// Assumes the inputs are already synchronous to clk.
module pic_pending #(
    parameter int NSRC  = 8,
    parameter int IDX_W = 3
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic [NSRC-1:0]  src_in,
    input  logic [NSRC-1:0]  src_lvlmode,
    input  logic             ack,
    input  logic [IDX_W-1:0] acc_idx,
    output logic [NSRC-1:0]  eff
);
    logic [NSRC-1:0] src_prev;
    logic [NSRC-1:0] pend;

    // Remember the previous input sample for edge detection.
    always_ff @(posedge clk) begin
        if (!rst_n) src_prev <= '0;
        else        src_prev <= src_in;
    end

    for (genvar i = 0; i < NSRC; i++) begin : g_src
        logic clr;
        assign clr = ack && (acc_idx == IDX_W'(i));

        // Edge flag: a new rise wins over a clear in the same cycle.
        always_ff @(posedge clk) begin
            if (!rst_n)              pend[i] <= 1'b0;
            else if (src_lvlmode[i]) pend[i] <= 1'b0;
            else                     pend[i] <= (src_in[i] && !src_prev[i]) || (pend[i] && !clr);
        end

        // Effective request seen by the resolver.
        assign eff[i] = src_lvlmode[i] ? src_in[i] : pend[i];
    end
endmodule

// File: rtl/pic_resolver.sv
// Priority resolution and pass sequencer. A pass lasts RES_CYCLES cycles and
// its last cycle picks the winner: lowest level, then lowest index, among
// sources whose level is below the mask. The request is held until a restart.
module pic_resolver
    import pic_pkg::*;
#(
    parameter int NSRC       = 8,
    parameter int IDX_W      = 3,
    parameter int VEC_W      = 16,
    parameter int RES_CYCLES = 2
) (
    input  logic                  clk,
    input  logic                  rst_n,
    input  logic [NSRC-1:0]       eff,
    input  lvl_t [NSRC-1:0]       src_lvl,
    input  lvl_t                  mask,
    input  logic [VEC_W-1:0]      base,
    input  logic                  restart,
    output logic                  irq,
    output logic [IDX_W-1:0]      acc_idx,
    output lvl_t                  acc_level,
    output logic [VEC_W-1:0]      vector
);
    localparam int CNT_W = (RES_CYCLES > 1) ? $clog2(RES_CYCLES) : 1;
    localparam logic [CNT_W-1:0] CNT_LAST = CNT_W'(RES_CYCLES - 1);

    seq_t             state;
    logic [CNT_W-1:0] cnt;
    logic             found;
    lvl_t             best_lvl;
    logic [IDX_W-1:0] best_idx;

    // Pick the best eligible source; strict compare keeps the lowest index on ties.
    always_comb begin
        found    = 1'b0;
        best_lvl = LVL_OFF;
        best_idx = '0;
        for (int i = 0; i < NSRC; i++) begin
            if (eff[i] && (src_lvl[i] < mask) && (!found || (src_lvl[i] < best_lvl))) begin
                found    = 1'b1;
                best_lvl = src_lvl[i];
                best_idx = IDX_W'(i);
            end
        end
    end

    // Pass sequencer: count, capture at the last cycle, then hold the request.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            state     <= SEQ_PASS;
            cnt       <= '0;
            irq       <= 1'b0;
            acc_idx   <= '0;
            acc_level <= LVL_OFF;
            vector    <= '0;
        end else if (restart) begin
            state <= SEQ_PASS;
            cnt   <= '0;
            irq   <= 1'b0;
        end else if (state == SEQ_PASS) begin
            if (cnt == CNT_LAST) begin
                cnt <= '0;
                if (found) begin
                    state     <= SEQ_HOLD;
                    irq       <= 1'b1;
                    acc_idx   <= best_idx;
                    acc_level <= best_lvl;
                    vector    <= base + VEC_W'({best_idx, 2'b00});
                end
            end else begin
                cnt <= cnt + 1'b1;
            end
        end
    end
endmodule

// File: rtl/pic_regs.sv
// Register bus decode with access side effects. A vector read while the request
// is high is the acknowledge. A mask write restarts resolution.
// Assumes single-cycle strobes and never a read and a write in the same cycle.
module pic_regs
    import pic_pkg::*;
#(
    parameter int NSRC   = 8,
    parameter int ADDR_W = 5,
    parameter int VEC_W  = 16
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              bus_rd,
    input  logic              bus_wr,
    input  logic [ADDR_W-1:0] bus_addr,
    input  logic [VEC_W-1:0]  bus_wdata,
    output logic [VEC_W-1:0]  bus_rdata,
    input  logic              irq_q,
    input  lvl_t              acc_level,
    input  logic [VEC_W-1:0]  vector,
    output lvl_t              mask,
    output logic [VEC_W-1:0]  base,
    output lvl_t [NSRC-1:0]   src_lvl,
    output logic [NSRC-1:0]   src_lvlmode,
    output logic              ack,
    output logic              mask_wr
);
    logic            hit_vec, hit_mask, hit_base;
    logic [NSRC-1:0] cfg_hit;

    assign hit_vec  = (bus_addr == ADDR_W'(REG_VEC));
    assign hit_mask = (bus_addr == ADDR_W'(REG_MASK));
    assign hit_base = (bus_addr == ADDR_W'(REG_BASE));
    assign ack      = bus_rd && hit_vec && irq_q;
    assign mask_wr  = bus_wr && hit_mask;

    // Mask: software write, or the accepted level on acknowledge.
    always_ff @(posedge clk) begin
        if (!rst_n)       mask <= LVL_OFF;
        else if (mask_wr) mask <= bus_wdata[LVL_W-1:0];
        else if (ack)     mask <= acc_level;
    end

    // Vector base register.
    always_ff @(posedge clk) begin
        if (!rst_n)                  base <= '0;
        else if (bus_wr && hit_base) base <= bus_wdata;
    end

    for (genvar i = 0; i < NSRC; i++) begin : g_cfg
        assign cfg_hit[i] = (bus_addr == ADDR_W'(REG_SRC0 + i));

        // Per-source level and recognition mode.
        always_ff @(posedge clk) begin
            if (!rst_n) begin
                src_lvl[i]     <= LVL_OFF;
                src_lvlmode[i] <= 1'b0;
            end else if (bus_wr && cfg_hit[i]) begin
                src_lvl[i]     <= bus_wdata[LVL_W-1:0];
                src_lvlmode[i] <= bus_wdata[LVL_W];
            end
        end
    end

    // Read multiplexer; unmapped addresses read zero.
    always_comb begin
        bus_rdata = '0;
        if (hit_vec)       bus_rdata = vector;
        else if (hit_mask) bus_rdata = VEC_W'(mask);
        else if (hit_base) bus_rdata = base;
        for (int i = 0; i < NSRC; i++) begin
            if (cfg_hit[i]) bus_rdata = VEC_W'({src_lvlmode[i], src_lvl[i]});
        end
    end
endmodule

// File: rtl/pic_top.sv
// Priority interrupt controller top. It ties the pending latches, the resolver
// and the register file together. Restart is an acknowledge or a mask write.
module pic_top
    import pic_pkg::*;
#(
    parameter int NSRC       = 8,
    parameter int ADDR_W     = 5,
    parameter int VEC_W      = 16,
    parameter int RES_CYCLES = 2
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic [NSRC-1:0]   irq_src,
    input  logic              bus_rd,
    input  logic              bus_wr,
    input  logic [ADDR_W-1:0] bus_addr,
    input  logic [VEC_W-1:0]  bus_wdata,
    output logic [VEC_W-1:0]  bus_rdata,
    output logic              irq_o
);
    localparam int IDX_W = (NSRC > 1) ? $clog2(NSRC) : 1;

    logic [NSRC-1:0]  eff;
    lvl_t [NSRC-1:0]  src_lvl;
    logic [NSRC-1:0]  src_lvlmode;
    lvl_t             mask;
    lvl_t             acc_level;
    logic [IDX_W-1:0] acc_idx;
    logic [VEC_W-1:0] base;
    logic [VEC_W-1:0] vec_q;
    logic             ack;
    logic             mask_wr;
    logic             restart;

    assign restart = ack || mask_wr;

    pic_regs #(.NSRC(NSRC), .ADDR_W(ADDR_W), .VEC_W(VEC_W)) u_regs (
        .clk(clk), .rst_n(rst_n), .bus_rd(bus_rd), .bus_wr(bus_wr),
        .bus_addr(bus_addr), .bus_wdata(bus_wdata), .bus_rdata(bus_rdata),
        .irq_q(irq_o), .acc_level(acc_level), .vector(vec_q),
        .mask(mask), .base(base), .src_lvl(src_lvl), .src_lvlmode(src_lvlmode),
        .ack(ack), .mask_wr(mask_wr)
    );

    pic_pending #(.NSRC(NSRC), .IDX_W(IDX_W)) u_pend (
        .clk(clk), .rst_n(rst_n), .src_in(irq_src), .src_lvlmode(src_lvlmode),
        .ack(ack), .acc_idx(acc_idx), .eff(eff)
    );

    pic_resolver #(.NSRC(NSRC), .IDX_W(IDX_W), .VEC_W(VEC_W), .RES_CYCLES(RES_CYCLES)) u_res (
        .clk(clk), .rst_n(rst_n), .eff(eff), .src_lvl(src_lvl), .mask(mask),
        .base(base), .restart(restart), .irq(irq_o), .acc_idx(acc_idx),
        .acc_level(acc_level), .vector(vec_q)
    );
endmodule

// File: rtl/pic_checker.sv
// Assertion checker for pic_top, attached by bind.
// Assumes a read and a write never occur in the same cycle.
module pic_checker
    import pic_pkg::*;
#(
    parameter int VEC_W = 16
) (
    input logic             clk,
    input logic             rst_n,
    input logic             irq,
    input logic             ack,
    input logic             mask_wr,
    input lvl_t             mask,
    input lvl_t             acc_level,
    input logic [VEC_W-1:0] vector
);
    p_ack_mask_r5: assert property (@(posedge clk) disable iff (!rst_n)
        ack |=> (mask == $past(acc_level)));

    p_restart_drop_r8: assert property (@(posedge clk) disable iff (!rst_n)
        (ack || mask_wr) |=> !irq);

    p_eligible_r2: assert property (@(posedge clk) disable iff (!rst_n)
        irq |-> (acc_level < mask));

    p_vector_hold_r4: assert property (@(posedge clk) disable iff (!rst_n)
        (irq && !ack && !mask_wr) |=> (irq && $stable(vector)));

    p_mask_hold_r9: assert property (@(posedge clk) disable iff (!rst_n)
        !(ack || mask_wr) |=> $stable(mask));
endmodule

bind pic_top pic_checker #(.VEC_W(VEC_W)) u_chk (
    .clk(clk), .rst_n(rst_n), .irq(irq_o), .ack(ack), .mask_wr(mask_wr),
    .mask(mask), .acc_level(acc_level), .vector(vec_q)
);

// File: tb/sim_pic_top.sv
`timescale 1ns/1ps
module sim_pic_top;
    localparam int NSRC = 8, ADDR_W = 5, VEC_W = 16, RES = 2;
    localparam int A_VEC = 0, A_MASK = 1, A_BASE = 2, A_SRC = 16;

    logic              clk = 1'b0;
    logic              rst_n = 1'b0;
    logic [NSRC-1:0]   irq_src = '0;
    logic              bus_rd = 1'b0, bus_wr = 1'b0;
    logic [ADDR_W-1:0] bus_addr = '0;
    logic [VEC_W-1:0]  bus_wdata = '0;
    logic [VEC_W-1:0]  bus_rdata;
    logic              irq_o;

    int n_chk = 0, n_fail = 0;
    int cfg_lvl[NSRC];
    int base_v = 0;

    always #2.5 clk = ~clk;

    pic_top #(.NSRC(NSRC), .ADDR_W(ADDR_W), .VEC_W(VEC_W), .RES_CYCLES(RES)) u0 (
        .clk(clk), .rst_n(rst_n), .irq_src(irq_src), .bus_rd(bus_rd), .bus_wr(bus_wr),
        .bus_addr(bus_addr), .bus_wdata(bus_wdata), .bus_rdata(bus_rdata), .irq_o(irq_o)
    );

    task automatic chk(input bit ok, input string req, input int act, input int exp);
        n_chk++;
        if (!ok) begin
            n_fail++;
            $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
        end
    endtask

    task automatic wr(input int a, input int d);
        @(negedge clk); bus_wr = 1'b1; bus_addr = ADDR_W'(a); bus_wdata = VEC_W'(d);
        @(negedge clk); bus_wr = 1'b0;
    endtask

    task automatic rd(input int a, output int d);
        @(negedge clk); bus_rd = 1'b1; bus_addr = ADDR_W'(a);
        #1 d = int'(bus_rdata);
        @(negedge clk); bus_rd = 1'b0;
    endtask

    task automatic cfg(input int i, input int lvl, input bit lvlmode);
        cfg_lvl[i] = lvl;
        wr(A_SRC + i, (int'(lvlmode) << 3) | lvl);
    endtask

    task automatic pulse(input logic [NSRC-1:0] m);
        @(negedge clk); irq_src = irq_src | m;
        @(negedge clk); irq_src = irq_src & ~m;
    endtask

    task automatic wait_irq(output bit seen);
        seen = 1'b0;
        for (int k = 0; k < 12 && !seen; k++) begin
            @(negedge clk);
            if (irq_o) seen = 1'b1;
        end
    endtask

    task automatic quiet(output bit ok);
        ok = 1'b1;
        for (int k = 0; k < 10; k++) begin
            @(negedge clk);
            if (irq_o) ok = 1'b0;
        end
    endtask

    // Expected winner: lowest level below mask, ties to lowest index; -1 if none.
    function automatic int exp_win(input logic [NSRC-1:0] p, input int m);
        int w = -1;
        for (int i = 0; i < NSRC; i++)
            if (p[i] && cfg_lvl[i] < m && (w < 0 || cfg_lvl[i] < cfg_lvl[w])) w = i;
        return w;
    endfunction

    function automatic int exp_vec(input int i);
        return (base_v + 4 * i) & 16'hffff;
    endfunction

    initial begin
        #(5.0 * 150000);
        n_fail++; n_chk++;
        $display("FAIL watchdog actual=running expected=done");
        $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
        $finish;
    end

    initial begin
        int d, w;
        bit ok;
        logic [NSRC-1:0] pend_m;
        for (int i = 0; i < NSRC; i++) cfg_lvl[i] = 7;
        void'($urandom(32'd4242));
        repeat (3) @(negedge clk);
        rst_n = 1'b1;

        // R1: reset state
        @(negedge clk);
        chk(irq_o == 1'b0, "R1 irq", int'(irq_o), 0);
        rd(A_MASK, d); chk(d == 7, "R1 mask", d, 7);
        rd(A_BASE, d); chk(d == 0, "R1 base", d, 0);
        rd(A_SRC + 3, d); chk(d == 7, "R1 cfg", d, 7);
        rd(5, d); chk(d == 0, "R11 unmapped", d, 0);
        // R9: vector read while request low has no side effect
        rd(A_VEC, d);
        rd(A_MASK, d); chk(d == 7, "R9 mask unchanged", d, 7);

        // R2 / R4 / R5 / R6 on an edge source
        base_v = 16'h1000; wr(A_BASE, base_v);
        wr(A_MASK, 3);
        cfg(2, 5, 1'b0);
        pulse(8'h04);
        quiet(ok); chk(ok, "R2 masked source silent", int'(irq_o), 0);
        wr(A_MASK, 7);
        wait_irq(ok); chk(ok, "R2 eligible raises", int'(ok), 1);
        rd(A_VEC, d); chk(d == exp_vec(2), "R4 vector", d, exp_vec(2));
        chk(irq_o == 1'b0, "R5 request dropped", int'(irq_o), 0);
        rd(A_MASK, d); chk(d == 5, "R5 mask loaded", d, 5);
        wr(A_MASK, 7);
        quiet(ok); chk(ok, "R6 edge cleared", int'(irq_o), 0);
        @(negedge clk); irq_src[2] = 1'b1;
        wait_irq(ok); chk(ok, "R6 rise pends", int'(ok), 1);
        rd(A_VEC, d);
        wr(A_MASK, 7);
        quiet(ok); chk(ok, "R6 held high no re-request", int'(irq_o), 0);
        irq_src[2] = 1'b0;
        cfg(2, 7, 1'b0);

        // R3: tie goes to lowest index, then next level
        cfg(1, 3, 1'b0); cfg(4, 2, 1'b0); cfg(6, 2, 1'b0);
        pulse(8'h52);
        wait_irq(ok); rd(A_VEC, d); chk(d == exp_vec(4), "R3 tie low index", d, exp_vec(4));
        wr(A_MASK, 7);
        wait_irq(ok); rd(A_VEC, d); chk(d == exp_vec(6), "R3 second", d, exp_vec(6));
        wr(A_MASK, 7);
        wait_irq(ok); rd(A_VEC, d); chk(d == exp_vec(1), "R3 third", d, exp_vec(1));
        wr(A_MASK, 7);

        // R4: base change after capture leaves vector alone
        pulse(8'h10);
        wait_irq(ok);
        wr(A_BASE, 16'h2000);
        rd(A_VEC, d); chk(d == exp_vec(4), "R4 captured vector", d, exp_vec(4));
        base_v = 16'h2000;
        wr(A_MASK, 7);
        pulse(8'h10);
        wait_irq(ok); rd(A_VEC, d); chk(d == exp_vec(4), "R4 new base", d, exp_vec(4));
        wr(A_MASK, 7);

        // R7 / R8 / R10: level source
        cfg(5, 1, 1'b1);
        @(negedge clk); irq_src[5] = 1'b1;
        wait_irq(ok); chk(ok, "R7 level requests", int'(ok), 1);
        rd(A_VEC, d); chk(d == exp_vec(5), "R7 vector", d, exp_vec(5));
        rd(A_MASK, d); chk(d == 1, "R5 mask level", d, 1);
        quiet(ok); chk(ok, "R7 masked while level high", int'(irq_o), 0);
        wr(A_MASK, 7);
        for (int k = 0; k < RES - 1; k++) begin
            @(negedge clk); chk(irq_o == 1'b0, "R10 low during pass", int'(irq_o), 0);
        end
        @(negedge clk); chk(irq_o == 1'b1, "R10 rise on time", int'(irq_o), 1);
        wr(A_MASK, 7);
        chk(irq_o == 1'b0, "R8 same-value write drops", int'(irq_o), 0);
        wait_irq(ok); chk(ok, "R8 re-resolved", int'(ok), 1);
        rd(A_VEC, d); chk(d == exp_vec(5), "R7 same vector", d, exp_vec(5));
        irq_src[5] = 1'b0;
        wr(A_MASK, 7);
        quiet(ok); chk(ok, "R7 level released", int'(irq_o), 0);

        // Random: R3 / R4 / R5 / R6 against the bench model
        for (int i = 0; i < NSRC; i++) cfg(i, int'($urandom_range(0, 6)), 1'b0);
        for (int r = 0; r < 30; r++) begin
            pend_m = NSRC'($urandom_range(1, 255));
            pulse(pend_m);
            for (int s = 0; s < NSRC + 1; s++) begin
                w = exp_win(pend_m, 7);
                if (w < 0) begin
                    quiet(ok); chk(ok, "R6 drained", int'(irq_o), 0);
                    break;
                end
                wait_irq(ok);
                rd(A_VEC, d); chk(d == exp_vec(w), "R3 random winner", d, exp_vec(w));
                rd(A_MASK, d); chk(d == cfg_lvl[w], "R5 random mask", d, cfg_lvl[w]);
                pend_m[w] = 1'b0;
                wr(A_MASK, 7);
            end
        end

        $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
        $finish;
    end
endmodule